// File: doc/BRIEF.md
# Single-Bus Multi-Cycle Processor Core

This block is a small processor core. All transfers between its registers travel over one internal bus, and a hardwired control unit sequences them. Every instruction passes through a series of machine cycles. It always starts with an instruction fetch. A memory-indirect operand adds an address cycle, and every instruction then has an execute cycle. A pending and enabled interrupt adds an entry cycle at the end. Each machine cycle lasts a fixed number of clock beats, counted by a beat counter that returns to zero at the start of every machine cycle.

The bus can carry only one value per beat, and the adder has one input on the bus. The first addend is therefore parked in one operand latch and the second in another, and only then is the sum driven back onto the bus. Memory is a synchronous single-port array: the core drives the address from its address register, raises a read strobe, and takes the data on the next beat. Writes use a write strobe with data from the memory data register. Observation ports show the program counter, stack pointer, flags, interrupt enable, the general registers and the current machine cycle.

Top module: `cpu_bus_core`

## Requirements
- R1: After a synchronous reset, the PC, SP, IR, flags, interrupt enable and all general registers are zero, and `mcycle` is 0 (fetch). The `mcycle` codes are 0 fetch, 1 indirect, 2 execute, 3 interrupt.
- R2: Every instruction begins with a fetch cycle. The fetch performs exactly one memory read, at the address held in the PC. The IR takes the word read, and the PC advances by one on the beat that issues the read.
- R3: Each machine cycle lasts `BEATS` clocks (default 6). An instruction without an indirect operand takes two machine cycles. The memory-indirect add takes three. An interrupt entry adds one more.
- R4: The instruction word has these fields: opcode in bits [15:12], destination register in bits [11:10], source register in bits [9:8], address in bits [7:0]. The opcodes are 0 no-op, 1 register-indirect add, 2 memory-indirect add, 3 jump, 4 branch-if-negative, 5 enable interrupts. Any other opcode acts as a no-op.
- R5: Opcode 1 sets rd = rd + M[rs]. It makes two memory reads in total: the fetch and one operand read.
- R6: Opcode 2 sets rd = rd + M[M[addr]]. It is the only opcode that enters the indirect cycle, which reads the effective address. It makes three reads in total.
- R7: Only the two add opcodes update the flags. Flag bit 3 is signed overflow, bit 2 is the sign of the sum, bit 1 is set when the sum is zero, and bit 0 is the carry out.
- R8: A jump loads the address field into the PC. It makes no memory access besides the fetch and leaves the flags unchanged.
- R9: Branch-if-negative loads the address field into the PC only when flag bit 2 is set. Otherwise execution falls through to the next word.
- R10: At the end of an execute cycle with `irq` high and interrupts enabled, the core enters the interrupt cycle. There it first decrements SP, then writes the return PC to M[SP], loads `VECTOR` into the PC and clears the enable. With interrupts disabled, `irq` has no effect, and nothing writes memory outside this cycle.
- R11: The read and write strobes are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_addr | output | AW | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` on the next beat |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data from the memory data register |
| mem_rdata | input | DW | Read data from memory |
| obs_pc | output | AW | Program counter |
| obs_sp | output | AW | Stack pointer |
| obs_psw | output | 4 | Flags {V, N, Z, C} |
| obs_ie | output | 1 | Interrupt enable |
| obs_regs | output | NREG*DW | General registers, register k at bits [k*DW +: DW] |
| mcycle | output | 2 | Current machine cycle code |

## Verification
The hardest condition to reach from the ports is an interrupt request that is both pending and enabled at exactly the last beat of an execute cycle. The request line alone cannot produce it, because the enable can only be set by an instruction.

The stimulus holds `irq` high from reset onward. The early instructions therefore run with the request pending but ignored. An enable instruction is then placed after the flag-setting and branch sequence, so the entry cycle, the stack push and the vector load happen right after it. A loop at the vector re-enables interrupts, which repeats the entry and pushes the stack downward a second time.

A reference instruction-level model in the bench runs the same program. After every instruction the bench compares registers, PC, SP, flags, clock count, read count and write count against that model.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_INDIR = 2'd1,
        MC_EXEC  = 2'd2,
        MC_INTR  = 2'd3
    } mcyc_e;

    localparam logic [3:0] OPC_NOP  = 4'h0;
    localparam logic [3:0] OPC_ADD  = 4'h1;
    localparam logic [3:0] OPC_ADDM = 4'h2;
    localparam logic [3:0] OPC_JMP  = 4'h3;
    localparam logic [3:0] OPC_BN   = 4'h4;
    localparam logic [3:0] OPC_EI   = 4'h5;

    localparam int FLG_V = 3;
    localparam int FLG_N = 2;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_PC, SRC_IRA, SRC_REG, SRC_MDR, SRC_ALU, SRC_SP, SRC_VEC
    } bus_src_e;

    typedef struct packed {
        bus_src_e src;
        logic     reg_rs;
        logic     ld_mar;
        logic     ld_mdr_bus;
        logic     ld_mdr_mem;
        logic     ld_ir;
        logic     ld_la;
        logic     ld_lb;
        logic     ld_pc;
        logic     pc_inc;
        logic     ld_reg;
        logic     ld_psw;
        logic     sp_dec;
        logic     ie_set;
        logic     ie_clr;
        logic     mem_rd;
        logic     mem_wr;
    } ctrl_t;

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int RIW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RIW-1:0]     rd_idx,
    output logic [DW-1:0]      rd_data,
    input  logic               wr_en,
    input  logic [RIW-1:0]     wr_idx,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)                               r_q <= '0;
            else if (wr_en && wr_idx == RIW'(g))   r_q <= wr_data;
        end
        assign flat[g*DW +: DW] = r_q;
    end

    assign rd_data = flat[rd_idx*DW +: DW];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] la,
    input  logic [DW-1:0] lb,
    output logic [DW-1:0] sum,
    output logic [3:0]    flags
);
    import cpu_bus_pkg::*;
    logic [DW:0] wide;

    always_comb begin
        wide         = {1'b0, la} + {1'b0, lb};
        sum          = wide[DW-1:0];
        flags        = '0;
        flags[FLG_C] = wide[DW];
        flags[FLG_N] = wide[DW-1];
        flags[FLG_Z] = (wide[DW-1:0] == '0);
        flags[FLG_V] = (la[DW-1] == lb[DW-1]) && (wide[DW-1] != la[DW-1]);
    end
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl #(
    parameter int BEATS = 6,
    localparam int BW   = $clog2(BEATS)
) (
    input  cpu_bus_pkg::mcyc_e mcycle,
    input  logic [BW-1:0]      beat,
    input  logic [3:0]         op,
    input  logic               neg,
    input  logic               irq,
    input  logic               ie,
    output cpu_bus_pkg::ctrl_t ctl,
    output logic               last,
    output cpu_bus_pkg::mcyc_e next_cyc
);
    import cpu_bus_pkg::*;

    always_comb begin
        ctl     = '0;
        ctl.src = SRC_NONE;
        unique case (mcycle)
            MC_FETCH: case (int'(beat))
                0: begin ctl.src = SRC_PC;  ctl.ld_mar = 1'b1; end
                1: begin ctl.mem_rd = 1'b1; ctl.pc_inc = 1'b1; end
                2: ctl.ld_mdr_mem = 1'b1;
                3: begin ctl.src = SRC_MDR; ctl.ld_ir = 1'b1; end
                default: ;
            endcase
            MC_INDIR: case (int'(beat))
                0: begin ctl.src = SRC_IRA; ctl.ld_mar = 1'b1; end
                1: ctl.mem_rd = 1'b1;
                2: ctl.ld_mdr_mem = 1'b1;
                default: ;
            endcase
            MC_EXEC: begin
                if (op == OPC_ADD || op == OPC_ADDM) begin
                    case (int'(beat))
                        0: begin ctl.src = SRC_REG; ctl.ld_la = 1'b1; end
                        1: begin
                            ctl.src    = (op == OPC_ADD) ? SRC_REG : SRC_MDR;
                            ctl.reg_rs = 1'b1;
                            ctl.ld_mar = 1'b1;
                        end
                        2: ctl.mem_rd = 1'b1;
                        3: ctl.ld_mdr_mem = 1'b1;
                        4: begin ctl.src = SRC_MDR; ctl.ld_lb = 1'b1; end
                        5: begin ctl.src = SRC_ALU; ctl.ld_reg = 1'b1; ctl.ld_psw = 1'b1; end
                        default: ;
                    endcase
                end else if (beat == '0) begin
                    if (op == OPC_JMP || (op == OPC_BN && neg)) begin
                        ctl.src   = SRC_IRA;
                        ctl.ld_pc = 1'b1;
                    end
                    ctl.ie_set = (op == OPC_EI);
                end
            end
            MC_INTR: case (int'(beat))
                0: ctl.sp_dec = 1'b1;
                1: begin ctl.src = SRC_SP;  ctl.ld_mar = 1'b1; end
                2: begin ctl.src = SRC_PC;  ctl.ld_mdr_bus = 1'b1; end
                3: ctl.mem_wr = 1'b1;
                4: begin ctl.src = SRC_VEC; ctl.ld_pc = 1'b1; ctl.ie_clr = 1'b1; end
                default: ;
            endcase
            default: ;
        endcase
    end

    always_comb begin
        last = (beat == BW'(BEATS-1));
        unique case (mcycle)
            MC_FETCH: next_cyc = (op == OPC_ADDM) ? MC_INDIR : MC_EXEC;
            MC_INDIR: next_cyc = MC_EXEC;
            MC_EXEC:  next_cyc = (irq && ie) ? MC_INTR : MC_FETCH;
            default:  next_cyc = MC_FETCH;
        endcase
    end
endmodule

// File: rtl/cpu_bus_core.sv
module cpu_bus_core #(
    parameter int               DW       = 16,
    parameter int               AW       = 8,
    parameter int               NREG     = 4,
    parameter int               BEATS    = 6,
    parameter logic [AW-1:0]    VECTOR   = 8'h20,
    parameter logic [AW-1:0]    SP_RESET = '0,
    localparam int              RIW      = $clog2(NREG),
    localparam int              BW       = $clog2(BEATS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    output logic [AW-1:0]      obs_pc,
    output logic [AW-1:0]      obs_sp,
    output logic [3:0]         obs_psw,
    output logic               obs_ie,
    output logic [NREG*DW-1:0] obs_regs,
    output logic [1:0]         mcycle
);
    import cpu_bus_pkg::*;

    typedef struct packed {
        mcyc_e         cyc;
        logic [BW-1:0] beat;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [DW-1:0] ir;
        logic [AW-1:0] mar;
        logic [DW-1:0] mdr;
        logic [DW-1:0] la;
        logic [DW-1:0] lb;
        logic [3:0]    psw;
        logic          ie;
    } core_st_t;

    localparam core_st_t RST_ST = '{cyc: MC_FETCH, beat: '0, pc: '0, sp: SP_RESET,
                                    ir: '0, mar: '0, mdr: '0, la: '0, lb: '0,
                                    psw: '0, ie: 1'b0};

    core_st_t      st_q, st_d;
    ctrl_t         ctl;
    mcyc_e         next_cyc;
    logic          last;
    logic [DW-1:0] bus, reg_rdata, alu_sum;
    logic [3:0]    alu_flags;
    logic [3:0]    op_w;
    logic [BW-1:0] beat_w;
    logic [RIW-1:0] rd_fld, rs_fld;

    assign op_w   = st_q.ir[DW-1 -: 4];
    assign rd_fld = st_q.ir[DW-5 -: RIW];
    assign rs_fld = st_q.ir[DW-5-RIW -: RIW];
    assign beat_w = st_q.beat;

    cpu_ctrl #(.BEATS(BEATS)) u_ctrl (
        .mcycle(st_q.cyc), .beat(st_q.beat), .op(op_w), .neg(st_q.psw[FLG_N]),
        .irq(irq), .ie(st_q.ie), .ctl(ctl), .last(last), .next_cyc(next_cyc)
    );

    cpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst), .rd_idx(ctl.reg_rs ? rs_fld : rd_fld), .rd_data(reg_rdata),
        .wr_en(ctl.ld_reg), .wr_idx(rd_fld), .wr_data(bus), .flat(obs_regs)
    );

    cpu_alu #(.DW(DW)) u_alu (
        .la(st_q.la), .lb(st_q.lb), .sum(alu_sum), .flags(alu_flags)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_PC:  bus = DW'(st_q.pc);
            SRC_IRA: bus = DW'(st_q.ir[AW-1:0]);
            SRC_REG: bus = reg_rdata;
            SRC_MDR: bus = st_q.mdr;
            SRC_ALU: bus = alu_sum;
            SRC_SP:  bus = DW'(st_q.sp);
            SRC_VEC: bus = DW'(VECTOR);
            default: bus = '0;
        endcase

        st_d = st_q;
        if (last) begin
            st_d.beat = '0;
            st_d.cyc  = next_cyc;
        end else begin
            st_d.beat = st_q.beat + 1'b1;
        end
        if (ctl.ld_mar)     st_d.mar = bus[AW-1:0];
        if (ctl.ld_mdr_bus) st_d.mdr = bus;
        if (ctl.ld_mdr_mem) st_d.mdr = mem_rdata;
        if (ctl.ld_ir)      st_d.ir  = bus;
        if (ctl.ld_la)      st_d.la  = bus;
        if (ctl.ld_lb)      st_d.lb  = bus;
        if (ctl.pc_inc)     st_d.pc  = st_q.pc + 1'b1;
        if (ctl.ld_pc)      st_d.pc  = bus[AW-1:0];
        if (ctl.ld_psw)     st_d.psw = alu_flags;
        if (ctl.sp_dec)     st_d.sp  = st_q.sp - 1'b1;
        if (ctl.ie_set)     st_d.ie  = 1'b1;
        if (ctl.ie_clr)     st_d.ie  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_ST;
        else     st_q <= st_d;
    end

    assign mem_addr  = st_q.mar;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign mem_wdata = st_q.mdr;
    assign obs_pc    = st_q.pc;
    assign obs_sp    = st_q.sp;
    assign obs_psw   = st_q.psw;
    assign obs_ie    = st_q.ie;
    assign mcycle    = st_q.cyc;
endmodule

// File: rtl/cpu_bus_core_chk.sv
module cpu_bus_core_chk #(
    parameter int  AW    = 8,
    parameter int  BEATS = 6,
    localparam int BW    = $clog2(BEATS)
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic [1:0]    mcycle,
    input logic [BW-1:0] beat,
    input logic [3:0]    op,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          ie
);
    a_r1_reset_release: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc == '0 && mcycle == 2'd0 && !ie));

    a_r2_fetch_advance: assert property (@(posedge clk) disable iff (rst)
        (mcycle == 2'd0 && mem_rd) |=> (pc == AW'($past(mem_addr) + 1'b1)));

    a_r3_beat_range: assert property (@(posedge clk) disable iff (rst)
        beat < BW'(BEATS));

    a_r3_cycle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(mcycle) |-> beat == '0);

    a_r6_indir_only_addm: assert property (@(posedge clk) disable iff (rst)
        mcycle == 2'd1 |-> op == 4'h2);

    a_r8_no_data_read: assert property (@(posedge clk) disable iff (rst)
        (mcycle == 2'd2 && op != 4'h1 && op != 4'h2) |-> !mem_rd);

    a_r10_write_in_intr: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mcycle == 2'd3);

    a_r10_entry_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(mcycle == 2'd3) |-> ($past(ie) && $past(irq)));

    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind cpu_bus_core cpu_bus_core_chk #(.AW(AW), .BEATS(BEATS)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .mcycle(mcycle), .beat(beat_w), .op(op_w),
    .pc(obs_pc), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .ie(obs_ie)
);

// File: tb/cpu_bus_core_test.sv
module cpu_bus_core_test;
    localparam int DW = 16, AW = 8, NREG = 4, BEATS = 6;
    localparam logic [7:0] VEC = 8'h20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0;
    logic [AW-1:0] mem_addr;
    logic mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] obs_pc, obs_sp;
    logic [3:0] obs_psw;
    logic obs_ie;
    logic [NREG*DW-1:0] obs_regs;
    logic [1:0] mcycle;

    always #10 clk = ~clk;

    cpu_bus_core uut (
        .clk(clk), .rst(rst), .irq(irq), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .obs_pc(obs_pc), .obs_sp(obs_sp), .obs_psw(obs_psw), .obs_ie(obs_ie),
        .obs_regs(obs_regs), .mcycle(mcycle)
    );

    logic [DW-1:0] mem  [256];
    logic [DW-1:0] rmem [256];
    logic [DW-1:0] rr [NREG];
    logic [7:0] rpc, rsp;
    logic [3:0] rpsw;
    logic rie;
    int n_chk = 0, n_fail = 0;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    function automatic logic [15:0] enc(int op, int rd, int rs, int a);
        return {4'(op), 2'(rd), 2'(rs), 8'(a)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic put(int a, logic [15:0] v);
        mem[a]  = v;
        rmem[a] = v;
    endtask

    task automatic ref_add(int rd, logic [15:0] v);
        logic [16:0] s;
        s = {1'b0, rr[rd]} + {1'b0, v};
        rpsw[0] = s[16];
        rpsw[2] = s[15];
        rpsw[1] = (s[15:0] == 16'h0);
        rpsw[3] = (rr[rd][15] == v[15]) && (s[15] != rr[rd][15]);
        rr[rd] = s[15:0];
    endtask

    task automatic ref_step(output int cyc, output int rds, output int wrs,
                            output logic [7:0] faddr, output int op);
        logic [15:0] ins;
        logic [7:0] a, ea;
        int rd, rs, mc;
        faddr = rpc;
        ins = rmem[rpc];
        rpc = rpc + 8'd1;
        op = int'(ins[15:12]); rd = int'(ins[11:10]); rs = int'(ins[9:8]); a = ins[7:0];
        mc = 2; rds = 1; wrs = 0;
        case (op)
            1: begin ea = rr[rs][7:0]; ref_add(rd, rmem[ea]); rds = 2; end
            2: begin ea = rmem[a][7:0]; ref_add(rd, rmem[ea]); rds = 3; mc = 3; end
            3: rpc = a;
            4: if (rpsw[2]) rpc = a;
            5: rie = 1'b1;
            default: ;
        endcase
        if (rie && irq) begin
            rsp = rsp - 8'd1;
            rmem[rsp] = {8'h00, rpc};
            rpc = VEC;
            rie = 1'b0;
            mc++;
            wrs = 1;
        end
        cyc = mc * BEATS;
    endtask

    initial begin
        int cyc_cnt, rd_cnt, wr_cnt, k, wd;
        logic [7:0] first_addr;
        logic got_addr;
        logic [1:0] prev;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; rmem[i] = '0; end
        put(8'h00, enc(2, 2, 0, 8'h40));
        put(8'h01, enc(2, 1, 0, 8'h41));
        put(8'h02, enc(1, 1, 2, 0));
        put(8'h03, enc(4, 0, 0, 8'h08));
        put(8'h08, enc(1, 3, 2, 0));
        put(8'h09, enc(4, 0, 0, 8'h04));
        put(8'h0A, enc(2, 3, 0, 8'h42));
        put(8'h0B, enc(5, 0, 0, 0));
        put(8'h20, enc(1, 0, 2, 0));
        put(8'h21, enc(3, 0, 0, 8'h25));
        put(8'h25, enc(5, 0, 0, 0));
        put(8'h40, 16'h0050); put(8'h50, 16'h0060);
        put(8'h41, 16'h0051); put(8'h51, 16'h7FFF);
        put(8'h42, 16'h0052); put(8'h52, 16'hFFFF);
        put(8'h60, 16'h0001);
        for (int i = 0; i < NREG; i++) rr[i] = '0;
        rpc = '0; rsp = '0; rpsw = '0; rie = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 pc", 32'(obs_pc), 0);
        chk("R1 sp", 32'(obs_sp), 0);
        chk("R1 psw", 32'(obs_psw), 0);
        chk("R1 ie", 32'(obs_ie), 0);
        chk("R1 regs", 32'(obs_regs[31:0] | obs_regs[63:32]), 0);
        chk("R1 mcycle", 32'(mcycle), 0);
        rst = 1'b0;
        irq = 1'b1;

        prev = 2'd0; cyc_cnt = 0; rd_cnt = 0; wr_cnt = 0; k = 0; wd = 0;
        got_addr = 1'b0; first_addr = '0;
        while (k < 20 && wd < 5000) begin
            @(negedge clk);
            wd++;
            if (mcycle == 2'd0 && prev != 2'd0) begin
                int e_cyc, e_rd, e_wr, e_op;
                logic [7:0] e_fa;
                string tg;
                ref_step(e_cyc, e_rd, e_wr, e_fa, e_op);
                tg = (e_op == 1) ? "R5" : (e_op == 2) ? "R6" : (e_op == 3) ? "R8" :
                     (e_op == 4) ? "R9" : "R4";
                for (int i = 0; i < NREG; i++)
                    chk({tg, " reg"}, 32'(obs_regs[i*DW +: DW]), 32'(rr[i]));
                chk({tg, " pc"}, 32'(obs_pc), 32'(rpc));
                chk("R7 flags", 32'(obs_psw), 32'(rpsw));
                chk("R10 sp", 32'(obs_sp), 32'(rsp));
                chk("R10 ie", 32'(obs_ie), 32'(rie));
                chk("R10 writes", 32'(wr_cnt), 32'(e_wr));
                chk({tg, " reads"}, 32'(rd_cnt), 32'(e_rd));
                chk("R2 fetch addr", 32'(first_addr), 32'(e_fa));
                if (k > 0) chk("R3 clocks", 32'(cyc_cnt), 32'(e_cyc));
                k++;
                cyc_cnt = 0; rd_cnt = 0; wr_cnt = 0; got_addr = 1'b0;
            end
            cyc_cnt++;
            if (mem_rd) begin
                rd_cnt++;
                if (!got_addr) begin first_addr = mem_addr; got_addr = 1'b1; end
            end
            if (mem_wr) wr_cnt++;
            if (mem_rd && mem_wr) chk("R11 strobes", 1, 0);
            prev = mcycle;
        end
        if (k < 20) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R3 act=%0d exp=20", k);
        end
        // R10: stack contents after the pushes
        chk("R10 stack FF", 32'(mem[8'hFF]), 32'(rmem[8'hFF]));
        chk("R10 stack FE", 32'(mem[8'hFE]), 32'(rmem[8'hFE]));
        chk("R10 first return", 32'(mem[8'hFF]), 32'h000C);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule